// File: doc/BRIEF.md
# Oversampling Serial Port with Watermarked Queues

This block is a full-duplex asynchronous serial port. The transmitter and the receiver run on their own. Both take their timing from one programmable divisor. That divisor produces an oversample tick, and one bit lasts sixteen ticks. Bytes written by the host wait in an eight-entry transmit queue until the transmitter sends them. Bytes that the receiver decodes wait in an eight-entry receive queue until the host reads them.

The receiver looks for a high-to-low change on the idle line. It then takes the majority value of ticks 7, 8 and 9 inside each bit period. If that vote gives high during the start bit, the frame is treated as noise and dropped. Each queue has a watermark that the host sets. The two watermark conditions appear as pending bits, and each can be enabled onto one interrupt output. A small register port carries data, control, divisor, interrupt enable and interrupt pending. The block has no parity, no flow control and no modem lines.

Top module: `uart_os_top`

## Requirements
- R1: The serial output is high after reset and whenever no frame is in progress. A frame is one low start bit, then 8 data bits with the least significant bit first, then the stop bits, which are high.
- R2: The transmitter sends one stop bit when control bit 2 is 0 and two stop bits when it is 1. The setting is taken when a frame starts.
- R3: The oversample tick occurs once every divisor+1 clock cycles. Every bit on the line, transmit and receive, lasts 16 ticks.
- R4: The receiver sets each bit to the majority of its samples at ticks 7, 8 and 9. A disturbance that covers only one of those samples does not change the received byte.
- R5: After a falling edge, if the start-bit vote is high, the receiver drops the frame and goes back to idle without storing a byte.
- R6: The receive queue holds 8 bytes and drops any byte that arrives while it is full. A read at address 0 returns the oldest byte in bits 7:0 with bit 8 set to 0, and removes that byte. If the queue is empty, the read returns bit 8 set to 1.
- R7: A write at address 0 adds bits 7:0 to the transmit queue. The queue holds 8 bytes, and a write while it is full is dropped.
- R8: Control bit 0 enables the transmitter and control bit 1 enables the receiver. While the transmitter is disabled, queued bytes stay queued and the line stays high. While the receiver is disabled, the line is ignored.
- R9: Pending bit 0 is 1 while the transmit queue count is less than the transmit watermark, which is held in control bits 7:4.
- R10: Pending bit 1 is 1 while the receive queue count is greater than the receive watermark, which is held in control bits 11:8.
- R11: irq_o is the OR of the pending bits ANDed with the enable bits at address 3.
- R12: The register map is: 0 data, 1 control, 2 divisor (16 bits), 3 interrupt enable, 4 interrupt pending (read only). All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe; removes a byte when the address is data |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| tx_o | output | 1 | Serial output |
| rx_i | input | 1 | Serial input, asynchronous |
| irq_o | output | 1 | Interrupt request |

## Verification
The transmitter is tested with back-to-back bursts at two divisors and with both stop-bit settings. The time from one start edge to the next separates the 10-bit frame from the 11-bit frame, and separates a correct divisor from an off-by-one divisor. A burst of nine writes shows whether the full transmit queue drops a write. The receiver gets these inputs:
- clean frames;
- a frame with a short inverted pulse in the middle of one data bit, which a single-sample decision would get wrong but the majority vote does not;
- a short low pulse on the idle line, which tests start-bit rejection;
- a nine-frame burst that overflows the receive queue.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;
  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_DIV  = 3'd2;
  localparam logic [2:0] ADDR_IE   = 3'd3;
  localparam logic [2:0] ADDR_IP   = 3'd4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_os_fifo.sv
module uart_os_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q];
  assign cnt_o   = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end
endmodule

// File: rtl/uart_os_tx.sv
module uart_os_tx #(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       two_stop_i,
  input  logic       empty_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       line_o,
  output logic       busy_o
);
  localparam int TW = $clog2(OSR);

  logic          busy_q, stop2_q;
  logic [10:0]   sh_q;
  logic [3:0]    idx_q;
  logic [TW-1:0] tcnt_q;
  logic [3:0]    last_idx;

  assign last_idx = stop2_q ? 4'd10 : 4'd9;
  assign pop_o    = !busy_q && en_i && !empty_i;
  assign line_o   = busy_q ? sh_q[0] : 1'b1;
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      stop2_q <= 1'b0;
      sh_q    <= '1;
      idx_q   <= '0;
      tcnt_q  <= '0;
    end else if (!busy_q) begin
      if (pop_o) begin
        busy_q  <= 1'b1;
        sh_q    <= {2'b11, data_i, 1'b0};
        idx_q   <= '0;
        tcnt_q  <= '0;
        stop2_q <= two_stop_i;
      end
    end else if (tick_i) begin
      tcnt_q <= tcnt_q + 1'b1;
      if (tcnt_q == TW'(OSR - 1)) begin
        sh_q  <= {1'b1, sh_q[10:1]};
        idx_q <= idx_q + 1'b1;
        if (idx_q == last_idx) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       line_i,
  output logic       push_o,
  output logic [7:0] data_o
);
  localparam int TW = $clog2(OSR);
  localparam int MID = OSR / 2;

  rx_state_e     st_q;
  logic          s1_q, s2_q, prev_hi_q, push_q;
  logic [1:0]    smp_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic [TW-1:0] cnt_q;
  logic          vote;

  assign vote   = (smp_q[0] & smp_q[1]) | (smp_q[0] & s2_q) | (smp_q[1] & s2_q);
  assign push_o = push_q;
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= RX_IDLE;
      prev_hi_q <= 1'b1;
      push_q    <= 1'b0;
      smp_q     <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      cnt_q     <= '0;
    end else if (!en_i) begin
      st_q      <= RX_IDLE;
      prev_hi_q <= 1'b1;
      push_q    <= 1'b0;
    end else begin
      push_q <= 1'b0;
      if (tick_i) begin
        if (st_q == RX_IDLE) begin
          prev_hi_q <= s2_q;
          if (prev_hi_q && !s2_q) begin
            st_q  <= RX_START;
            cnt_q <= TW'(1);    // detection tick is sample 0
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == TW'(MID - 1)) smp_q[0] <= s2_q;
          if (cnt_q == TW'(MID))     smp_q[1] <= s2_q;
          if (cnt_q == TW'(MID + 1)) begin
            unique case (st_q)
              RX_START: if (vote) begin
                st_q      <= RX_IDLE;
                prev_hi_q <= s2_q;
              end
              RX_DATA: sh_q <= {vote, sh_q[7:1]};
              RX_STOP: begin
                push_q    <= vote;
                st_q      <= RX_IDLE;
                prev_hi_q <= vote;
              end
              default: ;
            endcase
          end
          if (cnt_q == TW'(OSR - 1)) begin
            if (st_q == RX_START) begin
              st_q  <= RX_DATA;
              bit_q <= '0;
            end else if (st_q == RX_DATA) begin
              bit_q <= bit_q + 1'b1;
              if (bit_q == 3'd7) st_q <= RX_STOP;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_os_top.sv
module uart_os_top
  import uart_os_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OSR   = 16,
  parameter int DIVW  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        tx_o,
  input  logic        rx_i,
  output logic        irq_o
);
  logic [DIVW-1:0] div_q, tcnt_q;
  logic            tick;
  logic            tx_en, rx_en, two_stop;
  logic [CW-1:0]   tx_wm, rx_wm;
  logic [1:0]      ie_q, ip;
  logic            tx_push, tx_pop, tx_empty, tx_full, tx_busy;
  logic [7:0]      tx_data;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0]      rx_byte, rx_data;

  // oversample tick: period div+1
  assign tick = (tcnt_q == '0);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tcnt_q <= '0;
    else if (tick) tcnt_q <= div_q;
    else           tcnt_q <= tcnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      two_stop <= 1'b0;
      tx_wm    <= '0;
      rx_wm    <= '0;
      ie_q     <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        ADDR_CTRL: begin
          tx_en    <= wdata_i[0];
          rx_en    <= wdata_i[1];
          two_stop <= wdata_i[2];
          tx_wm    <= wdata_i[4 +: CW];
          rx_wm    <= wdata_i[8 +: CW];
        end
        ADDR_DIV: div_q <= wdata_i[DIVW-1:0];
        ADDR_IE:  ie_q  <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  assign tx_push = wr_i && (addr_i == ADDR_DATA);
  assign rx_pop  = rd_i && (addr_i == ADDR_DATA);
  assign ip      = {(rx_cnt > rx_wm), (tx_cnt < tx_wm)};
  assign irq_o   = |(ip & ie_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_DATA: rdata_o = {7'd0, rx_empty, rx_data};
      ADDR_CTRL: begin
        rdata_o[0]       = tx_en;
        rdata_o[1]       = rx_en;
        rdata_o[2]       = two_stop;
        rdata_o[4 +: CW] = tx_wm;
        rdata_o[8 +: CW] = rx_wm;
      end
      ADDR_DIV:  rdata_o[DIVW-1:0] = div_q;
      ADDR_IE:   rdata_o[1:0] = ie_q;
      ADDR_IP:   rdata_o[1:0] = ip;
      default:   rdata_o = '0;
    endcase
  end

  uart_os_fifo #(.DW(8), .DEPTH(DEPTH)) tx_fifo_i (
    .clk_i, .rst_ni, .push_i(tx_push), .data_i(wdata_i[7:0]), .pop_i(tx_pop),
    .data_o(tx_data), .empty_o(tx_empty), .full_o(tx_full), .cnt_o(tx_cnt)
  );

  uart_os_fifo #(.DW(8), .DEPTH(DEPTH)) rx_fifo_i (
    .clk_i, .rst_ni, .push_i(rx_push), .data_i(rx_byte), .pop_i(rx_pop),
    .data_o(rx_data), .empty_o(rx_empty), .full_o(rx_full), .cnt_o(rx_cnt)
  );

  uart_os_tx #(.OSR(OSR)) tx_i (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(tx_en), .two_stop_i(two_stop),
    .empty_i(tx_empty), .data_i(tx_data), .pop_o(tx_pop), .line_o(tx_o),
    .busy_o(tx_busy)
  );

  uart_os_rx #(.OSR(OSR)) rx_i_u (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(rx_en), .line_i(rx_i),
    .push_o(rx_push), .data_o(rx_byte)
  );
endmodule

// File: rtl/uart_os_chk.sv
module uart_os_chk #(
  parameter int DEPTH = 8,
  parameter int DIVW  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick,
  input logic [DIVW-1:0] div_q,
  input logic            tx_o,
  input logic            tx_busy,
  input logic            tx_full,
  input logic            tx_push,
  input logic            rx_en,
  input logic            rx_push,
  input logic [CW-1:0]   tx_cnt,
  input logic [CW-1:0]   rx_cnt
);
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> tx_o);

  a_r3_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && div_q != '0 && $stable(div_q)) |=> !tick);

  a_r7_tx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CW'(DEPTH));

  a_r7_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full && tx_push) |=> (tx_cnt <= $past(tx_cnt)));

  a_r6_rx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CW'(DEPTH));

  a_r8_rx_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> !rx_push);
endmodule

bind uart_os_top uart_os_chk #(.DEPTH(DEPTH), .DIVW(DIVW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .div_q(div_q), .tx_o(tx_o),
  .tx_busy(tx_busy), .tx_full(tx_full), .tx_push(tx_push), .rx_en(rx_en),
  .rx_push(rx_push), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/uart_os_top_tb_top.sv
module uart_os_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tx_line, rx_line = 1'b1, irq;

  int checks = 0, failures = 0, cyc = 0;
  int bper = 16;       // clock cycles per bit, bench side
  bit tx_quiet = 1'b0;
  logic [7:0] mon_q[$];
  int         mon_t[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_os_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tx_o(tx_line), .rx_i(rx_line), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic set_div(input int d);
    reg_wr(3'd2, 16'(d));
    bper = 16 * (d + 1);
  endtask

  // serial driver into the receiver; glitch: 2-cycle inversion in the middle of bit 3
  task automatic send_rx(input logic [7:0] b, input bit glitch);
    @(negedge clk); rx_line = 1'b0; wait_cyc(bper);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      if (glitch && i == 3) begin
        wait_cyc(bper / 2); rx_line = ~b[i]; wait_cyc(2); rx_line = b[i];
        wait_cyc(bper - bper / 2 - 2);
      end else wait_cyc(bper);
    end
    rx_line = 1'b1; wait_cyc(2 * bper);
  endtask

  // monitor on the serial output
  initial begin
    logic [7:0] b;
    int t0, p;
    forever begin
      @(negedge clk);
      if (rst_n && tx_line == 1'b0) begin
        t0 = cyc; p = bper;
        wait_cyc(p / 2);
        for (int i = 0; i < 8; i++) begin
          wait_cyc(p); b[i] = tx_line;
        end
        wait_cyc(p);
        chk(tx_line == 1'b1, "R1 stop bit", tx_line, 1);
        mon_q.push_back(b); mon_t.push_back(t0);
        wait (tx_line == 1'b1);
      end
    end
  end

  // per-clock: disabled transmitter keeps the line high (R8)
  always @(negedge clk) if (rst_n && tx_quiet) chk(tx_line == 1'b1, "R8 tx off line", tx_line, 1);

  initial begin
    wait (cyc >= 150000);
    failures++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n0, gap;
    wait_cyc(3); rst_n = 1'b1; wait_cyc(2);

    // reset state
    chk(tx_line == 1'b1, "R1 reset line", tx_line, 1);
    chk(irq == 1'b0, "R11 reset irq", irq, 0);
    reg_rd(3'd4, d); chk(d == 16'h0, "R12 reset pending", d, 0);
    reg_rd(3'd2, d); chk(d == 16'h0, "R12 reset divisor", d, 0);
    reg_rd(3'd0, d); chk(d[8] == 1'b1, "R6 empty flag", d[8], 1);

    set_div(1);
    reg_wr(3'd1, 16'h0132);     // rx_en, tx_wm=3, rx_wm=1, tx off
    reg_rd(3'd1, d); chk(d == 16'h0132, "R12 ctrl readback", d, 16'h0132);
    tx_quiet = 1'b1;
    reg_wr(3'd0, 16'h0011); reg_wr(3'd0, 16'h0022);
    reg_rd(3'd4, d); chk(d[0] == 1'b1, "R9 tx below wm", d[0], 1);
    chk(irq == 1'b0, "R11 masked", irq, 0);
    reg_wr(3'd3, 16'h0001);
    @(negedge clk); chk(irq == 1'b1, "R11 enabled", irq, 1);
    reg_wr(3'd0, 16'h0033);
    reg_rd(3'd4, d); chk(d[0] == 1'b0, "R9 tx at wm", d[0], 0);
    @(negedge clk); chk(irq == 1'b0, "R11 cleared", irq, 0);
    for (int k = 4; k <= 9; k++) reg_wr(3'd0, 16'(k * 8'h11));
    wait_cyc(3 * bper);
    chk(mon_q.size() == 0, "R8 tx held", mon_q.size(), 0);

    // transmit burst, one stop bit
    tx_quiet = 1'b0;
    reg_wr(3'd1, 16'h0133);
    wait_cyc(12 * 10 * bper);
    chk(mon_q.size() == 8, "R7 full drop count", mon_q.size(), 8);
    for (int k = 0; k < 8 && k < mon_q.size(); k++)
      chk(mon_q[k] == 8'((k + 1) * 8'h11), "R1 tx byte", mon_q[k], (k + 1) * 8'h11);
    if (mon_t.size() >= 3) begin
      gap = mon_t[2] - mon_t[1];
      chk(gap >= 10 * bper - 4 && gap <= 10 * bper + 4, "R2 one stop spacing", gap, 10 * bper);
    end
    mon_q.delete(); mon_t.delete();

    // two stop bits
    reg_wr(3'd1, 16'h0137);
    reg_wr(3'd0, 16'h00A1); reg_wr(3'd0, 16'h005C);
    wait_cyc(3 * 11 * bper);
    chk(mon_q.size() == 2, "R2 count", mon_q.size(), 2);
    if (mon_t.size() == 2) begin
      gap = mon_t[1] - mon_t[0];
      chk(gap >= 11 * bper - 4 && gap <= 11 * bper + 4, "R2 two stop spacing", gap, 11 * bper);
      chk(mon_q[1] == 8'h5C, "R1 tx byte 2stop", mon_q[1], 8'h5C);
    end
    mon_q.delete(); mon_t.delete();

    // divisor 3
    reg_wr(3'd1, 16'h0133);
    set_div(3);
    reg_wr(3'd0, 16'h00C3); reg_wr(3'd0, 16'h003C);
    wait_cyc(3 * 10 * bper);
    chk(mon_q.size() == 2, "R3 count", mon_q.size(), 2);
    if (mon_t.size() == 2) begin
      gap = mon_t[1] - mon_t[0];
      chk(gap >= 10 * bper - 6 && gap <= 10 * bper + 6, "R3 bit period", gap, 10 * bper);
      chk(mon_q[0] == 8'hC3, "R3 byte", mon_q[0], 8'hC3);
    end
    mon_q.delete(); mon_t.delete();
    set_div(1);

    // receive
    send_rx(8'hA5, 1'b0);
    reg_rd(3'd4, d); chk(d[1] == 1'b0, "R10 rx at wm", d[1], 0);
    send_rx(8'h3C, 1'b0);
    reg_rd(3'd4, d); chk(d[1] == 1'b1, "R10 rx above wm", d[1], 1);
    reg_rd(3'd0, d); chk(d == 16'h00A5, "R6 rx byte 1", d, 16'h00A5);
    reg_rd(3'd0, d); chk(d == 16'h003C, "R6 rx byte 2", d, 16'h003C);
    reg_rd(3'd0, d); chk(d[8] == 1'b1, "R6 empty after", d[8], 1);

    // start glitch
    @(negedge clk); rx_line = 1'b0; wait_cyc(6); rx_line = 1'b1;
    wait_cyc(12 * bper);
    reg_rd(3'd0, d); chk(d[8] == 1'b1, "R5 glitch dropped", d[8], 1);

    // mid-bit disturbance
    send_rx(8'h69, 1'b1);
    reg_rd(3'd0, d); chk(d == 16'h0069, "R4 majority vote", d, 16'h0069);
    send_rx(8'h00, 1'b1);
    reg_rd(3'd0, d); chk(d == 16'h0000, "R4 majority vote 0", d, 16'h0000);

    // receive overflow
    for (int k = 0; k < 9; k++) send_rx(8'(8'h40 + k), 1'b0);
    for (int k = 0; k < 8; k++) begin
      reg_rd(3'd0, d); chk(d == 16'(8'h40 + k), "R6 overflow order", d, 8'h40 + k);
    end
    reg_rd(3'd0, d); chk(d[8] == 1'b1, "R6 ninth dropped", d[8], 1);

    // receiver disabled
    reg_wr(3'd1, 16'h0131);
    send_rx(8'h77, 1'b0);
    reg_wr(3'd1, 16'h0133);
    wait_cyc(4);
    reg_rd(3'd0, d); chk(d[8] == 1'b1, "R8 rx off ignored", d[8], 1);

    // transmitter disabled with a queued byte
    reg_wr(3'd1, 16'h0132);
    wait_cyc(2);
    tx_quiet = 1'b1;
    n0 = mon_q.size();
    reg_wr(3'd0, 16'h00EE);
    wait_cyc(25 * bper);
    chk(mon_q.size() == n0, "R8 tx off no frame", mon_q.size(), n0);
    tx_quiet = 1'b0;
    reg_wr(3'd1, 16'h0133);
    wait_cyc(12 * bper);
    chk(mon_q.size() == n0 + 1, "R8 tx resumes", mon_q.size(), n0 + 1);
    if (mon_q.size() == n0 + 1) chk(mon_q[n0] == 8'hEE, "R8 held byte", mon_q[n0], 8'hEE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule